// File: doc/BRIEF.md
# Flow-Control Status Calendar Sequencer

This block produces the continuous 2-bit flow-control status stream that a packet receiver sends back to its transmitter. Each clock it emits one word. A sequence starts with a framing word `11`. Next come the calendar slots, each carrying the status of the logical port that a mapping table assigns to that slot. The slot calendar runs a programmable number of times in a row. A single diagonal parity word covering the whole sequence follows, and then the next framing word opens the next sequence.

Two configuration words (A and B) each hold a slot-count field and a repetition field, both stored as one less than the value used. A select input picks which word governs the next sequence. The choice is sampled only at the framing boundary, so a sequence in flight never changes shape. A training input replaces the stream with continuous `11` words. When it is released, the sequencer restarts from slot 0 with fresh parity. An error output flags a configuration in use whose calendar is shorter than the number of active ports or longer than the mapping table.

The controller has four states:
- `ST_FRAME` emits `11`, latches the configuration and seeds the parity.
- `ST_SLOT` walks the slots and repetitions.
- `ST_PARITY` emits the parity word.
- `ST_TRAIN` emits `11` while training is forced.

Transitions:
- `ST_FRAME` goes to `ST_SLOT`.
- `ST_SLOT` stays in `ST_SLOT` until the last slot of the last repetition, then goes to `ST_PARITY`.
- `ST_PARITY` goes to `ST_FRAME`.
- `ST_TRAIN` goes to `ST_FRAME`.
- An asserted `force_train` overrides every transition and leads to `ST_TRAIN`.

Top module: `status_cal_seq`

## Requirements
- R1: During reset and in the first cycle after reset, `stat_out` is `11` (framing). The next cycle carries slot 0.
- R2: The number of slots per calendar pass is (length field + 1) × 4. The length field is bits [4:0] of the configuration word, so a field of 4 gives 20 slots.
- R3: The calendar repeats (repeat field + 1) times, and the repeat field is bits [7:5]. Within each pass, slot s carries the status of the port that table entry s mod 64 selects. Port p's status is `port_status[2p+1:2p]`.
- R4: After the last slot of the last repetition, exactly one parity word is emitted. The framing word `11` follows it.
- R5: The parity accumulator is set to `11` when the framing word is sent. For each slot word w, the accumulator becomes (accumulator with its two bits swapped) XOR w. The parity word is the accumulator after the last slot.
- R6: A port status of `11` is sent as `10` (satisfied). A slot word is never `11`.
- R7: The mapping table has 64 entries and resets to entry i = i mod NPORT. A write with `map_we` high sets entry `map_addr` to `map_port` at the clock edge.
- R8: `cfg_sel` = 0 selects `cfg_a` and 1 selects `cfg_b`. The selected word is captured only at the edge that leaves a framing or training word. A change during a sequence first applies to the next sequence.
- R9: Once `force_train` is sampled high, `stat_out` is `11` from the next cycle for as long as the input stays high. After release, one framing word is sent, then slot 0 of repetition 0 with freshly seeded parity.
- R10: `cfg_err` is high while the configuration in use has fewer slots than `act_ports` or more than 64 slots. It reflects a newly captured configuration from the first slot of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_train | input | 1 | Replace the stream with `11` words |
| cfg_a | input | 8 | Configuration word A: repeat [7:5], length [4:0] |
| cfg_b | input | 8 | Configuration word B, same layout |
| cfg_sel | input | 1 | Selects configuration word B when high |
| act_ports | input | 4 | Number of active logical ports |
| map_we | input | 1 | Mapping table write enable |
| map_addr | input | 6 | Mapping table entry to write |
| map_port | input | 3 | Port number stored in the entry |
| port_status | input | 16 | 2-bit status per port, port p at [2p+1:2p] |
| stat_out | output | 2 | Status stream word for this cycle |
| cfg_err | output | 1 | Configuration in use is invalid |

## Verification
A wrong slot or repetition counter shows up at the ports as a wrong slot word within one cycle whenever neighbouring ports carry different statuses. It also shows up as a parity or framing word arriving one cycle early or late. Any error in the parity accumulator is seen in the single parity word at the end of the sequence, because the accumulator has no other visible output. A configuration that is captured at the wrong moment changes the length of the sequence in progress. That shifts every later parity and framing position, so the bench checks each word of every sequence it drives. Training misbehaviour shows in the first cycle after `force_train` is sampled, or in the first word after release.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        ST_FRAME  = 2'd0,
        ST_SLOT   = 2'd1,
        ST_PARITY = 2'd2,
        ST_TRAIN  = 2'd3
    } cal_state_e;

    localparam logic [1:0] FRAME_WORD = 2'b11;
    localparam logic [1:0] SATISFIED  = 2'b10;

    // diagonal parity step: swap lanes, then fold in the new word
    function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
        return {acc[0], acc[1]} ^ w;
    endfunction

endpackage

// File: rtl/cal_map_table.sv
module cal_map_table #(
    parameter int DEPTH = 64,
    parameter int NPORT = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(NPORT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wport,
    input  logic [AW-1:0] raddr,
    output logic [PW-1:0] rport
);
    logic [PW-1:0] tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= PW'(i % NPORT);
            end
        end else if (we) begin
            tbl[waddr] <= wport;
        end
    end

    assign rport = tbl[raddr];
endmodule

// File: rtl/cal_cfg_hold.sv
module cal_cfg_hold #(
    parameter int DEPTH  = 64,
    parameter int NPORT  = 8,
    parameter int LEN_FW = 5,
    parameter int REP_FW = 3,
    localparam int CFGW = LEN_FW + REP_FW,
    localparam int LSW  = LEN_FW + 3,
    localparam int RW   = REP_FW + 1,
    localparam int CW   = $clog2(NPORT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            sel,
    input  logic [CFGW-1:0] cfg_a,
    input  logic [CFGW-1:0] cfg_b,
    input  logic [CW-1:0]   act_ports,
    output logic [LSW-1:0]  len_slots,
    output logic [RW-1:0]   rep_max,
    output logic            cfg_err
);
    logic [LEN_FW-1:0] len_f;
    logic [REP_FW-1:0] rep_f;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_f <= '0;
            rep_f <= '0;
        end else if (load) begin
            {rep_f, len_f} <= sel ? cfg_b : cfg_a;
        end
    end

    assign len_slots = (LSW'(len_f) + LSW'(1)) << 2;
    assign rep_max   = RW'(rep_f) + RW'(1);
    assign cfg_err   = (LSW'(act_ports) > len_slots) || (len_slots > LSW'(DEPTH));
endmodule

// File: rtl/cal_dip.sv
module cal_dip (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed,
    input  logic       step,
    input  logic [1:0] word,
    output logic [1:0] par
);
    import cal_seq_pkg::*;

    logic [1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= FRAME_WORD;
        end else if (seed) begin
            acc_q <= dip_step(2'b00, FRAME_WORD);
        end else if (step) begin
            acc_q <= dip_step(acc_q, word);
        end
    end

    assign par = acc_q;
endmodule

// File: rtl/status_cal_seq.sv
module status_cal_seq #(
    parameter int NPORT  = 8,
    parameter int DEPTH  = 64,
    parameter int LEN_FW = 5,
    parameter int REP_FW = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(NPORT),
    localparam int CW   = $clog2(NPORT + 1),
    localparam int CFGW = LEN_FW + REP_FW,
    localparam int LSW  = LEN_FW + 3,
    localparam int RW   = REP_FW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_train,
    input  logic [CFGW-1:0]   cfg_a,
    input  logic [CFGW-1:0]   cfg_b,
    input  logic              cfg_sel,
    input  logic [CW-1:0]     act_ports,
    input  logic              map_we,
    input  logic [AW-1:0]     map_addr,
    input  logic [PW-1:0]     map_port,
    input  logic [2*NPORT-1:0] port_status,
    output logic [1:0]        stat_out,
    output logic              cfg_err
);
    import cal_seq_pkg::*;

    cal_state_e     state_q, state_d;
    logic [LSW-1:0] slot_q;
    logic [RW-1:0]  rep_q;
    logic [LSW-1:0] len_slots;
    logic [RW-1:0]  rep_max;
    logic [PW-1:0]  cur_port;
    logic [1:0]     raw_status, slot_word, par;
    logic           last_slot, last_rep, cfg_load;

    cal_map_table #(.DEPTH(DEPTH), .NPORT(NPORT)) map_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .waddr (map_addr),
        .wport (map_port),
        .raddr (slot_q[AW-1:0]),
        .rport (cur_port)
    );

    assign cfg_load = (state_q == ST_FRAME) || (state_q == ST_TRAIN);

    cal_cfg_hold #(.DEPTH(DEPTH), .NPORT(NPORT), .LEN_FW(LEN_FW), .REP_FW(REP_FW)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .sel       (cfg_sel),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .act_ports (act_ports),
        .len_slots (len_slots),
        .rep_max   (rep_max),
        .cfg_err   (cfg_err)
    );

    assign raw_status = port_status[{cur_port, 1'b0} +: 2];
    assign slot_word  = (raw_status == FRAME_WORD) ? SATISFIED : raw_status;

    cal_dip dip_i (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (state_q == ST_FRAME),
        .step  (state_q == ST_SLOT),
        .word  (slot_word),
        .par   (par)
    );

    assign last_slot = (slot_q == len_slots - LSW'(1));
    assign last_rep  = (rep_q == rep_max - RW'(1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (force_train) begin
            state_d = ST_TRAIN;
        end else begin
            unique case (state_q)
                ST_FRAME:  state_d = ST_SLOT;
                ST_SLOT:   state_d = (last_slot && last_rep) ? ST_PARITY : ST_SLOT;
                ST_PARITY: state_d = ST_FRAME;
                ST_TRAIN:  state_d = ST_FRAME;
            endcase
        end
    end

    // state register and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FRAME;
            slot_q  <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SLOT) begin
                if (last_slot) begin
                    slot_q <= '0;
                    rep_q  <= rep_q + RW'(1);
                end else begin
                    slot_q <= slot_q + LSW'(1);
                end
            end else begin
                slot_q <= '0;
                rep_q  <= '0;
            end
        end
    end

    // output word per state
    always_comb begin
        unique case (state_q)
            ST_SLOT:   stat_out = slot_word;
            ST_PARITY: stat_out = par;
            ST_FRAME:  stat_out = FRAME_WORD;
            ST_TRAIN:  stat_out = FRAME_WORD;
        endcase
    end
endmodule

// File: rtl/status_cal_seq_chk.sv
module status_cal_seq_chk #(
    parameter int LSW = 8,
    parameter int RW  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   force_train,
    input cal_seq_pkg::cal_state_e state_q,
    input logic [1:0]             stat_out,
    input logic [LSW-1:0]         slot_q,
    input logic [RW-1:0]          rep_q,
    input logic [LSW-1:0]         len_slots,
    input logic [RW-1:0]          rep_max
);
    import cal_seq_pkg::*;

    // R6
    slot_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT) |-> (stat_out != 2'b11));

    // R4
    parity_then_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARITY && !force_train) |=> (state_q == ST_FRAME && stat_out == 2'b11));

    // R9
    train_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_train |=> (stat_out == 2'b11));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && !force_train) |=> (state_q == ST_SLOT && slot_q == '0 && rep_q == '0));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT) |=> ($stable(len_slots) && $stable(rep_max)));

    // R3
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT) |-> (slot_q < len_slots && rep_q < rep_max));
endmodule

bind status_cal_seq status_cal_seq_chk #(.LSW(LSW), .RW(RW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_train (force_train),
    .state_q     (state_q),
    .stat_out    (stat_out),
    .slot_q      (slot_q),
    .rep_q       (rep_q),
    .len_slots   (len_slots),
    .rep_max     (rep_max)
);

// File: tb/status_cal_seq_tb_top.sv
module status_cal_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        force_train;
    logic [7:0]  cfg_a, cfg_b;
    logic        cfg_sel;
    logic [3:0]  act_ports;
    logic        map_we;
    logic [5:0]  map_addr;
    logic [2:0]  map_port;
    logic [15:0] port_status;
    logic [1:0]  stat_out;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [2:0] mmap [64];

    status_cal_seq dut_i (
        .clk(clk), .rst_n(rst_n), .force_train(force_train), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .cfg_sel(cfg_sel), .act_ports(act_ports), .map_we(map_we), .map_addr(map_addr),
        .map_port(map_port), .port_status(port_status), .stat_out(stat_out), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_word(input int slot);
        logic [2:0] p;
        logic [1:0] w;
        p = mmap[slot % 64];
        w = port_status[2*p +: 2];
        return (w == 2'b11) ? 2'b10 : w;
    endfunction

    // starts sampled in a framing cycle, ends sampled in the next one
    task automatic expect_seq(input int lf, input int rf, input bit mid, input logic [7:0] mid_cfg,
                              input string req);
        logic [1:0] acc, e;
        acc = 2'b11;
        for (int r = 0; r <= rf; r++) begin
            for (int s = 0; s < (lf + 1) * 4; s++) begin
                step();
                if (mid && r == 0 && s == 1) cfg_a = mid_cfg;
                e = exp_word(s);
                check(stat_out == e, req, stat_out, e);
                acc = {acc[0], acc[1]} ^ e;
            end
        end
        step();
        check(stat_out == acc, "R5 parity word", stat_out, acc);
        step();
        check(stat_out == 2'b11, "R4 framing after parity", stat_out, 3);
    endtask

    task automatic retrain();
        force_train = 1'b1;
        step();
        check(stat_out == 2'b11, "R9 training word", stat_out, 3);
        step();
        check(stat_out == 2'b11, "R9 training held", stat_out, 3);
        force_train = 1'b0;
        step();
        check(stat_out == 2'b11, "R9 framing after release", stat_out, 3);
    endtask

    task automatic t_reset();
        check(stat_out == 2'b11, "R1 reset framing", stat_out, 3);
        expect_seq(0, 0, 1'b0, 8'h00, "R1 first sequence");
    endtask

    task automatic t_lengths();
        port_status = 16'b10_01_00_10_01_00_01_10;
        cfg_a = {3'd0, 5'd1};
        expect_seq(1, 0, 1'b0, 8'h00, "R2 eight slots");
        cfg_a = {3'd2, 5'd4};
        expect_seq(4, 2, 1'b0, 8'h00, "R2 R3 twenty slots three passes");
        port_status = 16'b00_10_01_00_10_10_00_01;
        cfg_a = {3'd7, 5'd0};
        expect_seq(0, 7, 1'b0, 8'h00, "R3 eight passes");
    endtask

    task automatic t_select_map();
        force_train = 1'b1;
        step();
        for (int i = 0; i < 8; i++) begin
            map_we = 1'b1; map_addr = 6'(i); map_port = 3'(7 - i); mmap[i] = 3'(7 - i);
            step();
        end
        map_we = 1'b0;
        cfg_b = {3'd1, 5'd1};
        cfg_sel = 1'b1;
        force_train = 1'b0;
        step();
        check(stat_out == 2'b11, "R9 framing after release", stat_out, 3);
        expect_seq(1, 1, 1'b0, 8'h00, "R7 R8 remapped slots on config B");
        cfg_sel = 1'b0;
    endtask

    task automatic t_reserved();
        port_status = 16'b11_11_01_00_11_10_00_11;
        cfg_a = {3'd0, 5'd1};
        expect_seq(1, 0, 1'b0, 8'h00, "R6 reserved status sent as satisfied");
    endtask

    task automatic t_mid_change();
        port_status = 16'b01_10_00_01_10_00_01_10;
        cfg_a = {3'd0, 5'd1};
        expect_seq(1, 0, 1'b1, {3'd1, 5'd0}, "R8 change held until boundary");
        expect_seq(0, 1, 1'b0, 8'h00, "R8 new config after boundary");
    endtask

    task automatic t_train_mid();
        cfg_a = {3'd1, 5'd2};
        step(); step(); step();
        retrain();
        expect_seq(2, 1, 1'b0, 8'h00, "R9 restart from slot zero");
    endtask

    task automatic t_err();
        act_ports = 4'd5;
        cfg_a = {3'd0, 5'd0};
        retrain();
        step();
        check(cfg_err == 1'b1, "R10 four slots five ports", cfg_err, 1);
        cfg_a = {3'd0, 5'd1};
        retrain();
        step();
        check(cfg_err == 1'b0, "R10 eight slots five ports", cfg_err, 0);
        cfg_a = {3'd0, 5'd16};
        retrain();
        step();
        check(cfg_err == 1'b1, "R10 sixty-eight slots", cfg_err, 1);
        cfg_a = {3'd0, 5'd15};
        retrain();
        step();
        check(cfg_err == 1'b0, "R10 sixty-four slots", cfg_err, 0);
        act_ports = 4'd4;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mmap[i] = 3'(i % 8);
        rst_n = 1'b0; force_train = 1'b0; cfg_a = 8'h00; cfg_b = 8'h00; cfg_sel = 1'b0;
        act_ports = 4'd4; map_we = 1'b0; map_addr = '0; map_port = '0;
        port_status = 16'b10_01_00_10_01_00_10_01;
        repeat (3) @(posedge clk);
        #1;
        check(stat_out == 2'b11, "R1 framing in reset", stat_out, 3);
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_select_map();
        t_reserved();
        t_mid_change();
        t_train_mid();
        t_err();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule